// File: doc/BRIEF.md
# Two-Threshold Lockable Watchdog Counter

This block is an up-counting watchdog with two programmable limits. It counts one step per clock while it is allowed to run. When the count reaches the first limit (the bark), it raises a level interrupt request. If wakeup is enabled, it also raises a level wakeup request, so that a sleeping system can come back and service the interrupt. Both stay high until software acknowledges them or the block is reset. When the count reaches the second limit (the bite), it raises a reset request. That request stays high until the block itself is reset, so no acknowledge is needed after a bite.

Software keeps the watchdog quiet by loading zero into the count, known as petting. Three things can stop counting:
- the enable input going low;
- an external run gate, used to freeze the count during debug or after the system has been put into a killed state;
- a pause option that freezes the count while a low-power indication is active.

The register lock and the bus side sit outside this block. It sees only the already-decoded configuration values and a count write strobe.

Top module: `wdog_bark_bite`

## Requirements
- R1: While reset is active, and after it is released, the count is 0 and the interrupt, wakeup and reset-request outputs are all 0.
- R2: A count step happens only when `enable_i`, `run_i` and the term NOT(`pause_sleep_i` AND `sleep_i`) are all 1. On a step, `count_o` rises by exactly one on the next clock.
- R3: With `pause_sleep_i`=1 and `sleep_i`=1 the count holds. With only one of the two set, counting continues.
- R4: With `run_i`=0 the count holds its value.
- R5: A cycle with `cnt_wr_i`=1 loads `cnt_wdata_i` into the count on the next clock. The write takes priority over a step, and writing zero is the pet.
- R6: On the clock after a cycle in which `enable_i`=1 and count >= `bark_thr_i`, `bark_irq_o` is 1. It then stays 1 until a cycle with `bark_ack_i`=1.
- R7: `wake_req_o` is set in the same way as the bark, but only when `wake_en_i`=1. It is cleared by the same acknowledge, and it is never 1 while `bark_irq_o` is 0.
- R8: If an acknowledge arrives in a cycle where the bark condition still holds, the set wins and both outputs stay 1.
- R9: On the clock after a cycle in which `enable_i`=1 and count >= `bite_thr_i`, `bite_rst_o` is 1. Neither the acknowledge nor a pet clears it; only reset does.
- R10: The count saturates at all ones and does not wrap.
- R11: With `enable_i`=0 the count holds, and no threshold hit is recorded whatever the count and thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Watchdog enable |
| run_i | input | 1 | External run gate; 0 freezes the count |
| pause_sleep_i | input | 1 | Pause-in-sleep option |
| sleep_i | input | 1 | Low-power state indication |
| wake_en_i | input | 1 | Allows the bark to raise a wakeup request |
| bark_thr_i | input | CNT_W | First (interrupt) threshold |
| bite_thr_i | input | CNT_W | Second (reset) threshold |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Value loaded by a count write |
| bark_ack_i | input | 1 | Software acknowledge of bark and wakeup |
| count_o | output | CNT_W | Current count |
| bark_irq_o | output | 1 | Level bark interrupt request |
| wake_req_o | output | 1 | Level wakeup request |
| bite_rst_o | output | 1 | Level reset request |

## Verification
The bench runs with a narrow counter so that every bark threshold from 0 upward, the bite offset above it, and saturation at all ones are reached exhaustively.

It targets the following corner cases, and what a faulty design would do in each:

| Corner case | What a faulty design would do |
|---|---|
| Off-by-one at the threshold | Raise the bark or bite one clock early or late |
| Threshold of zero | Fire too early, or not at all |
| Wrap instead of saturate | Drop the count back to zero and restart |
| Acknowledge while the condition still holds | Lose the interrupt |
| Gating terms | Let pause-with-sleep, the run gate or a disabled watchdog still count |
| Disabled watchdog with a stale count above the limit | Record a hit anyway |
| Pet | Fail to hold off either threshold |
| Acknowledge or pet after a bite | Wrongly clear the reset request |

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Sticky outputs of the watchdog, kept together as one record
  typedef struct packed {
    logic bark;
    logic wake;
    logic bite;
  } wdog_flags_t;

  localparam int unsigned STAGE_BARK = 0;
  localparam int unsigned STAGE_BITE = 1;
  localparam int unsigned NUM_STAGES = 2;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             at_max;
  logic             cnt_en;

  assign at_max = (count_q == CNT_MAX);

  // Next-state: a write wins over a step; the count saturates at the top
  always_comb begin
    count_d = count_q;
    cnt_en  = 1'b0;
    if (wr_i) begin
      count_d = wdata_i;
      cnt_en  = 1'b1;
    end else if (tick_i && !at_max) begin
      count_d = count_q + CNT_W'(1);
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/wdog_cmp.sv
module wdog_cmp #(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             hit_o
);

  // Reached-or-passed test, so a threshold lowered below the count still fires
  assign hit_o = (count_i >= thr_i);

endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable_i,
  input  logic        wake_en_i,
  input  logic        ack_i,
  input  logic        bark_hit_i,
  input  logic        bite_hit_i,
  output wdog_flags_t flags_o
);

  wdog_flags_t flags_q, flags_d;
  logic        bark_set;
  logic        bite_set;

  assign bark_set = enable_i & bark_hit_i;
  assign bite_set = enable_i & bite_hit_i;

  // Set has priority over acknowledge; the bite has no clear but reset
  always_comb begin
    flags_d.bark = bark_set | (flags_q.bark & ~ack_i);
    flags_d.wake = (bark_set & wake_en_i) | (flags_q.wake & ~ack_i);
    flags_d.bite = bite_set | flags_q.bite;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned RST_SYNCS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic             pause_sleep_i,
  input  logic             sleep_i,
  input  logic             wake_en_i,
  input  logic [CNT_W-1:0] bark_thr_i,
  input  logic [CNT_W-1:0] bite_thr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             bark_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             bark_irq_o,
  output logic             wake_req_o,
  output logic             bite_rst_o
);

  logic                               rst_core_n;
  logic                               cnt_tick;
  logic [CNT_W-1:0]                   count;
  logic [NUM_STAGES-1:0][CNT_W-1:0]   thr_arr;
  logic [NUM_STAGES-1:0]              hit_arr;
  wdog_flags_t                        flags;

  wdog_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Count gate: enabled, run gate open, not paused by sleep
  assign cnt_tick = enable_i & run_i & ~(pause_sleep_i & sleep_i);

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_i  (cnt_tick),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .count_o (count)
  );

  assign thr_arr[STAGE_BARK] = bark_thr_i;
  assign thr_arr[STAGE_BITE] = bite_thr_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    wdog_cmp #(.CNT_W(CNT_W)) u_cmp (
      .count_i (count),
      .thr_i   (thr_arr[g]),
      .hit_o   (hit_arr[g])
    );
  end

  wdog_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable_i   (enable_i),
    .wake_en_i  (wake_en_i),
    .ack_i      (bark_ack_i),
    .bark_hit_i (hit_arr[STAGE_BARK]),
    .bite_hit_i (hit_arr[STAGE_BITE]),
    .flags_o    (flags)
  );

  assign count_o    = count;
  assign bark_irq_o = flags.bark;
  assign wake_req_o = flags.wake;
  assign bite_rst_o = flags.bite;

endmodule

// File: rtl/wdog_bark_bite_chk.sv
module wdog_bark_bite_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run_i,
  input logic             pause_sleep_i,
  input logic             sleep_i,
  input logic             enable_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             bark_ack_i,
  input logic [CNT_W-1:0] count_o,
  input logic             bark_irq_o,
  input logic             wake_req_o,
  input logic             bite_rst_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R3
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_sleep_i && sleep_i && !cnt_wr_i) |=> $stable(count_o));

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr_i) |=> $stable(count_o));

  // R5
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (count_o == $past(cnt_wdata_i)));

  // R6
  bark_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_irq_o && !bark_ack_i) |=> bark_irq_o);

  // R7
  wake_bark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> bark_irq_o);

  // R9
  bite_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite_rst_o |=> bite_rst_o);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !cnt_wr_i) |=> (count_o == CNT_MAX));

  // R11
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !cnt_wr_i) |=> $stable(count_o));

endmodule

bind wdog_bark_bite wdog_bark_bite_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .tick          (cnt_tick),
  .run_i         (run_i),
  .pause_sleep_i (pause_sleep_i),
  .sleep_i       (sleep_i),
  .enable_i      (enable_i),
  .cnt_wr_i      (cnt_wr_i),
  .cnt_wdata_i   (cnt_wdata_i),
  .bark_ack_i    (bark_ack_i),
  .count_o       (count_o),
  .bark_irq_o    (bark_irq_o),
  .wake_req_o    (wake_req_o),
  .bite_rst_o    (bite_rst_o)
);

// File: tb/sim_wdog_bark_bite.sv
`timescale 1ns/1ps
module sim_wdog_bark_bite;

  localparam int unsigned W = 4;
  localparam int unsigned MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         enable_i, run_i, pause_sleep_i, sleep_i, wake_en_i;
  logic [W-1:0] bark_thr_i, bite_thr_i, cnt_wdata_i;
  logic         cnt_wr_i, bark_ack_i;
  logic [W-1:0] count_o;
  logic         bark_irq_o, wake_req_o, bite_rst_o;

  int n_chk;
  int n_fail;

  wdog_bark_bite #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .run_i(run_i),
    .pause_sleep_i(pause_sleep_i), .sleep_i(sleep_i), .wake_en_i(wake_en_i),
    .bark_thr_i(bark_thr_i), .bite_thr_i(bite_thr_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .bark_ack_i(bark_ack_i), .count_o(count_o),
    .bark_irq_o(bark_irq_o), .wake_req_o(wake_req_o), .bite_rst_o(bite_rst_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    enable_i = 0; run_i = 1; pause_sleep_i = 0; sleep_i = 0; wake_en_i = 0;
    bark_thr_i = '1; bite_thr_i = '1; cnt_wr_i = 0; cnt_wdata_i = '0;
    bark_ack_i = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (3) cyc();
  endtask

  task automatic check_out(input int c, input int b, input int wk, input int bt, input string tag);
    check(int'(count_o), c, {tag, " count"});
    check(int'(bark_irq_o), b, {tag, " bark"});
    check(int'(wake_req_o), wk, {tag, " wake"});
    check(int'(bite_rst_o), bt, {tag, " bite"});
  endtask

  initial begin
    #(20000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    idle_inputs();
    rst_n = 0;
    repeat (2) cyc();
    // R1: outputs held low during reset
    check_out(0, 0, 0, 0, "R1 in reset");
    do_reset();
    check_out(0, 0, 0, 0, "R1 after reset");

    // R2 R6 R7 R9: sweep bark threshold, bite three above it
    for (int bt = 0; bt < 8; bt++) begin
      do_reset();
      bark_thr_i = W'(bt);
      bite_thr_i = W'(bt + 3);
      wake_en_i  = bt[0];
      enable_i   = 1;
      for (int n = 1; n <= 14; n++) begin
        cyc();
        check_out(n, int'(n >= bt + 1), int'(bt[0] && n >= bt + 1),
                  int'(n >= bt + 4), "R2 R6 R7 R9 sweep");
      end
    end

    // R10: saturation at all ones, threshold at the top
    do_reset();
    bark_thr_i = W'(MAXV);
    bite_thr_i = W'(MAXV);
    enable_i = 1;
    for (int n = 1; n <= 20; n++) begin
      cyc();
      check(int'(count_o), (n < MAXV) ? n : MAXV, "R10 saturate count");
      check(int'(bark_irq_o), int'(n >= MAXV + 1), "R10 bark at top");
    end

    // R3 R4 R11: gating terms
    do_reset();
    enable_i = 1;
    repeat (3) cyc();
    check(int'(count_o), 3, "R2 plain count");
    sleep_i = 1;
    repeat (2) cyc();
    check(int'(count_o), 5, "R3 sleep without pause counts");
    pause_sleep_i = 1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      check(int'(count_o), 5, "R3 pause in sleep holds");
    end
    sleep_i = 0;
    repeat (2) cyc();
    check(int'(count_o), 7, "R3 pause without sleep counts");
    run_i = 0;
    for (int k = 0; k < 3; k++) begin
      cyc();
      check(int'(count_o), 7, "R4 run low holds");
    end
    run_i = 1;
    enable_i = 0;
    bark_thr_i = 0;
    bite_thr_i = 0;
    for (int k = 0; k < 3; k++) begin
      cyc();
      check_out(7, 0, 0, 0, "R11 disabled no hit");
    end

    // R6 R7 R8: raise, ack against a live condition, then clear
    bite_thr_i = '1;
    wake_en_i = 1;
    enable_i = 1;
    cyc();
    check_out(8, 1, 1, 0, "R6 R7 bark with wake");
    bark_ack_i = 1;
    cyc();
    check_out(9, 1, 1, 0, "R8 set beats ack");
    bark_ack_i = 0;
    bark_thr_i = '1;
    cnt_wr_i = 1;
    cnt_wdata_i = 0;
    cyc();
    check_out(0, 1, 1, 0, "R6 held after pet without ack");
    cnt_wr_i = 0;
    bark_ack_i = 1;
    cyc();
    check_out(1, 0, 0, 0, "R6 R7 ack clears");
    bark_ack_i = 0;

    // R9: bite is not cleared by ack or pet
    bite_thr_i = 2;
    cyc();
    check(int'(bite_rst_o), 0, "R9 below bite");
    cyc();
    check(int'(bite_rst_o), 1, "R9 bite raised");
    bite_thr_i = '1;
    for (int k = 0; k < 3; k++) begin
      bark_ack_i = 1;
      cnt_wr_i = 1;
      cyc();
      check(int'(bite_rst_o), 1, "R9 bite sticky");
      check(int'(count_o), 0, "R5 pet zero");
    end
    bark_ack_i = 0;
    cnt_wr_i = 0;
    do_reset();
    check_out(0, 0, 0, 0, "R1 R9 reset clears bite");

    // R5: periodic petting holds off both thresholds; write beats step
    bark_thr_i = 5;
    bite_thr_i = 7;
    enable_i = 1;
    for (int it = 0; it < 6; it++) begin
      cnt_wr_i = 1;
      cnt_wdata_i = 0;
      cyc();
      cnt_wr_i = 0;
      check_out(0, 0, 0, 0, "R5 pet");
      for (int k = 1; k <= 4; k++) begin
        cyc();
        check_out(k, 0, 0, 0, "R5 between pets");
      end
    end
    bark_thr_i = '1;
    bite_thr_i = '1;
    cnt_wr_i = 1;
    cnt_wdata_i = 9;
    cyc();
    cnt_wr_i = 0;
    check(int'(count_o), 9, "R5 write priority over step");
    cyc();
    check(int'(count_o), 10, "R2 count resumes after load");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule